// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order integer core with fetch, decode, execute, memory and writeback stages. It runs a six-instruction subset: two register-to-register ALU operations, a word load, a word store, a not-equal branch whose immediate is an absolute byte address, and a halt. The core holds eight 32-bit general registers, none of them special; register 0 is as writable as the rest. Instruction and data storage are two separate 16-word arrays. The surrounding environment fills them through a load port while reset is held.

Operands move between stages by forwarding. One bubble is inserted when an instruction in decode needs the result of a load that is still in execute. Each instruction slot has its own 2-bit saturating counter that gives a direction hint to decode. A hinted-taken branch sends fetch to its target straight from decode. Every branch is then resolved in execute, and on a wrong hint the two younger stages are cleared. When a halt reaches writeback the core freezes and raises `halted`. Debug ports return any register or data word so that results can be read.

Top module: `pipe5_core`

## Requirements
- R1: Synchronous reset sets the PC to 0, all registers to 0, every prediction counter to 1 (weakly not taken) and all pipeline registers to bubbles, so `halted` is 0.
- R2: The word layout is opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and immediate [15:0]. Register numbers use the low three bits of each field. Opcode 0 with funct 32 writes rs+rt to rd. Opcode 0 with funct 34 writes rs−rt to rd. Both wrap modulo 2^32.
- R3: Opcode 35 loads into rt, and opcode 43 stores rt. The address is rs plus the zero-extended immediate, and bits [5:2] of that sum pick the data word. All other address bits are ignored.
- R4: Register 0 is an ordinary register. It keeps whatever value is written to it.
- R5: A result is forwarded to the next instruction and the one after it. Dependent ALU operations and stores that follow each other get correct values with no lost cycles.
- R6: If an instruction in decode reads the destination of a load in execute, exactly one bubble is inserted. The result is still correct.
- R7: The register file is write-first. An instruction in decode sees a value that is being written back in the same cycle.
- R8: Opcode 4 branches to the immediate, used as an absolute byte address, when rs ≠ rt. Otherwise execution falls through.
- R9: Each instruction slot has a 2-bit counter. Values 2 and 3 predict taken, and decode then redirects fetch at a cost of one bubble. A correct outcome saturates the counter to 3 (taken) or 0 (not taken). A wrong outcome moves it one step toward the actual direction.
- R10: A wrong prediction, detected in execute, clears the two younger stages and loads the PC with the correct address. This costs two cycles.
- R11: Opcode 63 is halt, and its operand fields are ignored. When halt reaches writeback, `halted` goes high and stays high, the PC freezes, and no younger instruction writes a register or memory.
- R12: An instruction word of 0, or any unlisted encoding, changes no architectural state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Write `ld_data` into instruction word `ld_addr` |
| ld_dmem_we | input | 1 | Write `ld_data` into data word `ld_addr` |
| ld_addr | input | 4 | Word index for the load port |
| ld_data | input | 32 | Load port data |
| dbg_reg_sel | input | 3 | Register selected for debug read |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_sel | input | 4 | Data word selected for debug read |
| dbg_mem_data | output | 32 | Contents of the selected data word |
| halted | output | 1 | High once halt has reached writeback |
| pc | output | 32 | Current fetch address |

## Verification
The bench sweeps two small programs. One runs over operand pairs that include zero, all-ones and signed-overflow values. The other runs a countdown loop for every trip count from 1 to 12. The pairs check the forwarding and stall paths: a missing stall or a wrongly ordered forwarding source leaves a register holding a stale load or the sum of an older instruction. A read-first register file leaves the loaded operand of the stalled add stale. The loop sweep checks the exact run length, which depends on the counter walk. A wrong initial counter value, a missing saturation step, or a flush of only one stage changes the cycle count or lets the halt that follows the branch retire too early. Each run ends by checking that the instruction after halt never writes and that the PC holds still.

// File: rtl/p5_pkg.sv
`timescale 1ns/1ps
package p5_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 3;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BNE   = 6'd4;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;
    localparam logic [5:0] OPC_HALT  = 6'd63;
    localparam logic [5:0] FN_ADD    = 6'd32;
    localparam logic [5:0] FN_SUB    = 6'd34;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [REG_AW-1:0] ridx_t;

    // zero encoding is the bubble
    typedef enum logic [2:0] {
        K_NOP  = 3'd0,
        K_ADD  = 3'd1,
        K_SUB  = 3'd2,
        K_LW   = 3'd3,
        K_SW   = 3'd4,
        K_BNE  = 3'd5,
        K_HALT = 3'd6
    } kind_e;

    typedef enum logic [1:0] {
        FW_FILE = 2'd0,
        FW_MEM  = 2'd1,
        FW_WB   = 2'd2
    } fwd_e;

    typedef struct packed {
        kind_e       kind;
        ridx_t       rs;
        ridx_t       rt;
        ridx_t       dst;
        logic        wr;
        logic        use_rs;
        logic        use_rt;
        logic [15:0] imm;
    } dec_t;

    typedef struct packed {
        word_t instr;
        word_t pc4;
    } ifid_t;

    typedef struct packed {
        dec_t  d;
        word_t a;
        word_t b;
        word_t pc4;
        word_t tgt;
        logic  pred;
    } idex_t;

    typedef struct packed {
        kind_e kind;
        ridx_t dst;
        logic  wr;
        word_t res;
        word_t sdata;
    } exmem_t;

    typedef struct packed {
        kind_e kind;
        ridx_t dst;
        logic  wr;
        word_t val;
    } memwb_t;

    function automatic dec_t decode(input word_t ins);
        dec_t d;
        d     = '0;
        d.rs  = ins[21 +: REG_AW];
        d.rt  = ins[16 +: REG_AW];
        d.imm = ins[15:0];
        case (ins[31:26])
            OPC_RTYPE: begin
                if (ins[5:0] == FN_ADD || ins[5:0] == FN_SUB) begin
                    d.kind   = (ins[5:0] == FN_ADD) ? K_ADD : K_SUB;
                    d.dst    = ins[11 +: REG_AW];
                    d.wr     = 1'b1;
                    d.use_rs = 1'b1;
                    d.use_rt = 1'b1;
                end
            end
            OPC_LW: begin
                d.kind   = K_LW;
                d.dst    = ins[16 +: REG_AW];
                d.wr     = 1'b1;
                d.use_rs = 1'b1;
            end
            OPC_SW: begin
                d.kind   = K_SW;
                d.use_rs = 1'b1;
                d.use_rt = 1'b1;
            end
            OPC_BNE: begin
                d.kind   = K_BNE;
                d.use_rs = 1'b1;
                d.use_rt = 1'b1;
            end
            OPC_HALT: d.kind = K_HALT;
            default:  d.kind = K_NOP;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/p5_regfile.sv
`timescale 1ns/1ps
module p5_regfile
    import p5_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t ra1,
    output word_t rd1,
    input  ridx_t ra2,
    output word_t rd2,
    input  ridx_t ra3,
    output word_t rd3
);
    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // same-cycle writeback wins over the stored value
    assign rd1 = (we && waddr == ra1) ? wdata : regs[ra1];
    assign rd2 = (we && waddr == ra2) ? wdata : regs[ra2];
    assign rd3 = regs[ra3];
endmodule

// File: rtl/p5_hazard.sv
`timescale 1ns/1ps
module p5_hazard
    import p5_pkg::*;
(
    input  dec_t  id_d,
    input  kind_e ex_kind,
    input  logic  ex_wr,
    input  ridx_t ex_dst,
    input  ridx_t ex_rs,
    input  ridx_t ex_rt,
    input  kind_e mem_kind,
    input  logic  mem_wr,
    input  ridx_t mem_dst,
    input  logic  wb_wr,
    input  ridx_t wb_dst,
    output logic  stall,
    output fwd_e  fwd_a,
    output fwd_e  fwd_b
);
    function automatic fwd_e pick(input ridx_t src, input kind_e mk, input logic mw,
                                  input ridx_t md, input logic ww, input ridx_t wd);
        if (mw && mk != K_LW && md == src) return FW_MEM;
        if (ww && wd == src)               return FW_WB;
        return FW_FILE;
    endfunction

    always_comb begin
        stall = (ex_kind == K_LW) && ex_wr &&
                ((id_d.use_rs && id_d.rs == ex_dst) || (id_d.use_rt && id_d.rt == ex_dst));
        fwd_a = pick(ex_rs, mem_kind, mem_wr, mem_dst, wb_wr, wb_dst);
        fwd_b = pick(ex_rt, mem_kind, mem_wr, mem_dst, wb_wr, wb_dst);
    end
endmodule

// File: rtl/p5_predictor.sv
`timescale 1ns/1ps
module p5_predictor #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_taken,
    input  logic          up_en,
    input  logic [IW-1:0] up_idx,
    input  logic          up_taken,
    input  logic          up_pred
);
    logic [1:0] ctr [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr[i] <= 2'd1;
        end else if (up_en) begin
            if (up_taken == up_pred)
                ctr[up_idx] <= up_taken ? 2'd3 : 2'd0;
            else if (up_taken)
                ctr[up_idx] <= ctr[up_idx] + 2'd1;
            else
                ctr[up_idx] <= ctr[up_idx] - 2'd1;
        end
    end

    assign rd_taken = ctr[rd_idx][1];
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
    import p5_pkg::*;
#(
    parameter int IMEM_WORDS = 16,
    parameter int DMEM_WORDS = 16,
    parameter int NREGS      = 8,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS),
    localparam int LD_W = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_imem_we,
    input  logic              ld_dmem_we,
    input  logic [LD_W-1:0]   ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    input  logic [REG_AW-1:0] dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_data,
    input  logic [DA_W-1:0]   dbg_mem_sel,
    output logic [XLEN-1:0]   dbg_mem_data,
    output logic              halted,
    output logic [XLEN-1:0]   pc
);
    word_t imem [IMEM_WORDS];
    word_t dmem [DMEM_WORDS];

    word_t  pc_q;
    ifid_t  ifid_q;
    idex_t  idex_q;
    exmem_t exmem_q;
    memwb_t memwb_q;

    assign halted = (memwb_q.kind == K_HALT);
    assign pc     = pc_q;

    // ---------------- storage load port ----------------
    always_ff @(posedge clk) begin
        if (ld_imem_we) imem[IA_W'(ld_addr)] <= ld_data;
    end

    // ---------------- fetch ----------------
    word_t if_instr;
    assign if_instr = imem[IA_W'(pc_q >> 2)];

    // ---------------- decode ----------------
    dec_t  id_d;
    word_t rf_a, rf_b, id_tgt;
    logic  hint_taken, id_pred;
    logic [IA_W-1:0] id_slot;

    assign id_d    = decode(ifid_q.instr);
    assign id_tgt  = word_t'(id_d.imm);
    assign id_slot = IA_W'((ifid_q.pc4 - 32'd4) >> 2);
    assign id_pred = (id_d.kind == K_BNE) && hint_taken;

    p5_regfile #(.NREGS(NREGS)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (memwb_q.wr),
        .waddr (memwb_q.dst),
        .wdata (memwb_q.val),
        .ra1   (id_d.rs),
        .rd1   (rf_a),
        .ra2   (id_d.rt),
        .rd2   (rf_b),
        .ra3   (dbg_reg_sel),
        .rd3   (dbg_reg_data)
    );

    // ---------------- hazards ----------------
    logic stall;
    fwd_e fwd_a, fwd_b;

    p5_hazard hz_i (
        .id_d     (id_d),
        .ex_kind  (idex_q.d.kind),
        .ex_wr    (idex_q.d.wr),
        .ex_dst   (idex_q.d.dst),
        .ex_rs    (idex_q.d.rs),
        .ex_rt    (idex_q.d.rt),
        .mem_kind (exmem_q.kind),
        .mem_wr   (exmem_q.wr),
        .mem_dst  (exmem_q.dst),
        .wb_wr    (memwb_q.wr),
        .wb_dst   (memwb_q.dst),
        .stall    (stall),
        .fwd_a    (fwd_a),
        .fwd_b    (fwd_b)
    );

    // ---------------- execute ----------------
    word_t ex_a, ex_b, ex_res, ex_fix_pc;
    logic  ex_is_br, ex_taken, ex_redirect;
    logic [IA_W-1:0] ex_slot;

    always_comb begin
        case (fwd_a)
            FW_MEM:  ex_a = exmem_q.res;
            FW_WB:   ex_a = memwb_q.val;
            default: ex_a = idex_q.a;
        endcase
        case (fwd_b)
            FW_MEM:  ex_b = exmem_q.res;
            FW_WB:   ex_b = memwb_q.val;
            default: ex_b = idex_q.b;
        endcase
        case (idex_q.d.kind)
            K_ADD:      ex_res = ex_a + ex_b;
            K_SUB:      ex_res = ex_a - ex_b;
            K_LW, K_SW: ex_res = ex_a + word_t'(idex_q.d.imm);
            default:    ex_res = '0;
        endcase
    end

    assign ex_is_br    = (idex_q.d.kind == K_BNE);
    assign ex_taken    = ex_is_br && (ex_a != ex_b);
    assign ex_redirect = ex_is_br && (ex_taken != idex_q.pred);
    assign ex_fix_pc   = ex_taken ? idex_q.tgt : idex_q.pc4;
    assign ex_slot     = IA_W'((idex_q.pc4 - 32'd4) >> 2);

    p5_predictor #(.DEPTH(IMEM_WORDS)) bp_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (id_slot),
        .rd_taken (hint_taken),
        .up_en    (ex_is_br && !halted),
        .up_idx   (ex_slot),
        .up_taken (ex_taken),
        .up_pred  (idex_q.pred)
    );

    // ---------------- memory ----------------
    logic [DA_W-1:0] mem_idx;
    word_t           mem_val;

    assign mem_idx      = DA_W'(exmem_q.res >> 2);
    assign mem_val      = (exmem_q.kind == K_LW) ? dmem[mem_idx] : exmem_q.res;
    assign dbg_mem_data = dmem[dbg_mem_sel];

    always_ff @(posedge clk) begin
        if (ld_dmem_we)
            dmem[DA_W'(ld_addr)] <= ld_data;
        else if (!rst && !halted && exmem_q.kind == K_SW)
            dmem[mem_idx] <= exmem_q.sdata;
    end

    // ---------------- next-state bundles ----------------
    idex_t  idex_n;
    exmem_t exmem_n;
    memwb_t memwb_n;
    ifid_t  ifid_n;

    always_comb begin
        idex_n.d    = id_d;
        idex_n.a    = rf_a;
        idex_n.b    = rf_b;
        idex_n.pc4  = ifid_q.pc4;
        idex_n.tgt  = id_tgt;
        idex_n.pred = id_pred;

        exmem_n.kind  = idex_q.d.kind;
        exmem_n.dst   = idex_q.d.dst;
        exmem_n.wr    = idex_q.d.wr;
        exmem_n.res   = ex_res;
        exmem_n.sdata = ex_b;

        memwb_n.kind = exmem_q.kind;
        memwb_n.dst  = exmem_q.dst;
        memwb_n.wr   = exmem_q.wr;
        memwb_n.val  = mem_val;

        ifid_n.instr = if_instr;
        ifid_n.pc4   = pc_q + 32'd4;
    end

    // ---------------- pipeline advance ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            ifid_q  <= '0;
            idex_q  <= '0;
            exmem_q <= '0;
            memwb_q <= '0;
        end else if (!halted) begin
            memwb_q <= memwb_n;
            exmem_q <= exmem_n;
            if (ex_redirect) begin
                idex_q <= '0;
                ifid_q <= '0;
                pc_q   <= ex_fix_pc;
            end else if (stall) begin
                idex_q <= '0;
            end else begin
                idex_q <= idex_n;
                if (id_pred) begin
                    ifid_q <= '0;
                    pc_q   <= id_tgt;
                end else begin
                    ifid_q <= ifid_n;
                    pc_q   <= ifid_n.pc4;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_q)));

    assert_loaduse_bubble_R6: assert property (@(posedge clk) disable iff (rst)
        (stall && !ex_redirect && !halted) |=> (idex_q.d.kind == K_NOP && !idex_q.d.wr && $stable(pc_q)));

    assert_mispredict_flush_R10: assert property (@(posedge clk) disable iff (rst)
        (ex_redirect && !halted) |=> (ifid_q.instr == '0 && idex_q.d.kind == K_NOP));

    assert_hint_redirect_R9: assert property (@(posedge clk) disable iff (rst)
        (id_pred && !stall && !ex_redirect && !halted) |=> (ifid_q.instr == '0 && pc_q == $past(id_tgt)));

    assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (idex_q.d.kind == K_NOP && !halted) |=> !exmem_q.wr);
endmodule

// File: tb/pipe5_core_tb_top.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0;
    logic        ld_dmem_we = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [3:0]  dbg_mem_sel = '0;
    logic [31:0] dbg_mem_data;
    logic        halted;
    logic [31:0] pc;

    always #10 clk = ~clk;  // 50 MHz

    pipe5_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .ld_imem_we   (ld_imem_we),
        .ld_dmem_we   (ld_dmem_we),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_sel  (dbg_mem_sel),
        .dbg_mem_data (dbg_mem_data),
        .halted       (halted),
        .pc           (pc)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] prog [16];
    logic [31:0] data [16];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic read_reg(input int idx, output logic [31:0] v);
        dbg_reg_sel = 3'(idx);
        #1;
        v = dbg_reg_data;
    endtask

    task automatic read_mem(input int idx, output logic [31:0] v);
        dbg_mem_sel = 4'(idx);
        #1;
        v = dbg_mem_data;
    endtask

    // load both arrays under reset, check reset state (R1), release
    task automatic start_prog();
        logic [31:0] v;
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b1; ld_dmem_we = 1'b0;
            ld_addr = 4'(i); ld_data = prog[i];
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b0; ld_dmem_we = 1'b1;
            ld_addr = 4'(i); ld_data = data[i];
        end
        @(negedge clk);
        ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
        @(negedge clk);
        chk("R1 reset pc", pc, 32'd0);
        chk("R1 reset halted", {31'd0, halted}, 32'd0);
        read_reg(3, v);
        chk("R1 reset r3", v, 32'd0);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(output int cyc);
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
            if (cyc > 400) begin
                n_vec++; n_bad++;
                $display("FAIL R11 watchdog: actual no halt expected halt");
                break;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        n_vec++; n_bad++;
        $display("FAIL global watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    logic [31:0] xs [8];
    logic [31:0] ys [8];

    initial begin
        int cyc;
        logic [31:0] v, pc_h;
        logic [31:0] x, y;

        xs[0] = 32'd0;          ys[0] = 32'd0;
        xs[1] = 32'd1;          ys[1] = 32'd2;
        xs[2] = 32'hFFFFFFFF;   ys[2] = 32'd1;
        xs[3] = 32'h80000000;   ys[3] = 32'h80000000;
        xs[4] = 32'd5;          ys[4] = 32'hFFFFFFFB;
        xs[5] = 32'h12345678;   ys[5] = 32'h9ABCDEF0;
        xs[6] = 32'd100;        ys[6] = 32'd7;
        xs[7] = 32'h7FFFFFFF;   ys[7] = 32'h7FFFFFFF;

        // ---------- sweep 1: ALU, loads, stores, forwarding ----------
        for (int p = 0; p < 8; p++) begin
            x = xs[p]; y = ys[p];
            for (int i = 0; i < 16; i++) begin prog[i] = '0; data[i] = '0; end
            data[0] = x; data[1] = y;
            prog[0]  = enc_i(6'd35, 0, 1, 16'd64);   // lw r1,64(r0): bits above [5:2] ignored
            prog[1]  = enc_i(6'd35, 0, 2, 16'd4);    // lw r2,4(r0)
            prog[2]  = enc_r(3, 1, 2, 6'd32);        // add r3,r1,r2 (load-use + write-first)
            prog[3]  = enc_r(4, 3, 1, 6'd34);        // sub r4,r3,r1
            prog[4]  = enc_r(0, 4, 3, 6'd32);        // add r0,r4,r3
            prog[5]  = enc_i(6'd43, 5, 0, 16'd8);    // sw r0,8(r5)
            prog[6]  = enc_i(6'd35, 7, 6, 16'd8);    // lw r6,8(r7)
            prog[7]  = enc_r(5, 6, 0, 6'd32);        // add r5,r6,r0 (load-use)
            prog[8]  = enc_r(7, 5, 4, 6'd34);        // sub r7,r5,r4
            prog[9]  = 32'd0;                        // no-op word
            prog[10] = enc_i(6'd63, 7, 7, 16'hFFFF); // halt, junk operands
            prog[11] = enc_r(1, 1, 1, 6'd32);        // after halt: must not retire
            start_prog();
            run_to_halt(cyc);
            chk("R6 cycles sweep1 (two load-use bubbles)", 32'(cyc), 32'd16);
            read_reg(1, v); chk("R3 r1 load via high address bits", v, x);
            read_reg(2, v); chk("R3 r2 load", v, y);
            read_reg(3, v); chk("R7 r3 add with write-first operand", v, x + y);
            read_reg(4, v); chk("R5 r4 sub forwarded", v, y);
            read_reg(0, v); chk("R4 r0 writable", v, x + y + y);
            read_mem(2, v); chk("R5 store of forwarded data", v, x + y + y);
            read_reg(6, v); chk("R3 r6 load after store", v, x + y + y);
            read_reg(5, v); chk("R6 r5 after load-use stall", v, 2 * (x + y + y));
            read_reg(7, v); chk("R2 r7 sub wrap", v, 2 * (x + y + y) - y);
            pc_h = pc;
            repeat (5) @(negedge clk);
            chk("R11 pc frozen after halt", pc, pc_h);
            chk("R11 halted stays high", {31'd0, halted}, 32'd1);
            read_reg(1, v); chk("R11 instruction after halt not retired", v, x);
            read_reg(7, v); chk("R12 halt and no-op leave r7", v, 2 * (x + y + y) - y);
        end

        // ---------- sweep 2: countdown loop, branch and prediction ----------
        for (int n = 1; n <= 12; n++) begin
            int exp_cyc;
            for (int i = 0; i < 16; i++) begin prog[i] = '0; data[i] = '0; end
            data[0] = 32'(n); data[1] = 32'd1;
            prog[0] = enc_i(6'd35, 0, 1, 16'd0);    // lw r1,0(r0)
            prog[1] = enc_i(6'd35, 0, 2, 16'd4);    // lw r2,4(r0)
            prog[2] = enc_r(4, 4, 2, 6'd32);        // add r4,r4,r2  (byte addr 8)
            prog[3] = enc_r(1, 1, 2, 6'd34);        // sub r1,r1,r2
            prog[4] = enc_i(6'd4, 1, 3, 16'd8);     // bne r1,r3,8 (absolute)
            prog[5] = enc_r(5, 4, 4, 6'd32);        // add r5,r4,r4
            prog[6] = enc_i(6'd63, 0, 0, 16'd0);    // halt
            start_prog();
            run_to_halt(cyc);
            // counter starts at 1: first taken costs 2, later taken cost 1, exit costs 2
            exp_cyc = (n == 1) ? 11 : (4 * n + 10);
            chk($sformatf("R9 R10 cycles loop n=%0d", n), 32'(cyc), 32'(exp_cyc));
            read_reg(1, v); chk("R8 r1 reaches zero", v, 32'd0);
            read_reg(4, v); chk("R8 loop trip count", v, 32'(n));
            read_reg(5, v); chk("R10 fall-through result", v, 32'(2 * n));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule